// File: doc/BRIEF.md
# LVDS Display Lane Packer

The block turns parallel pixel data into 7-bit words, one word per LVDS data lane per pixel clock, for a 7:1 serializer further down the path. Each port has four lanes. A pixel has 8-bit red, green and blue values and the DE, HS and VS controls. The two ports can run in three arrangements. In the first, only port A is active. In the second, the two ports form one 8-lane link: port A carries the odd pixel and port B carries the even pixel, and both groups carry port A's sync bits. In the third, the two ports are separate 4-lane links, each with its own sync bits. Each port works either in 24-bit color on four lanes or in 18-bit color on three lanes.

After packing comes a registered crossbar. It lets any of the eight physical lanes take any of the eight packed logical lanes, and it can invert the polarity of each physical lane. Software may write new select and invert settings at any time. A frame-sync state machine applies them only on the pixel where port A's VS rises, so a frame is never switched part-way through. Port A's VS can also be driven to a general-purpose output through a state machine that drops pulses lasting a single cycle.

Frame-sync states: `SYNC_HUNT` is entered at reset and waits for VS low, going to `SYNC_ARMED` when it sees VS low. `SYNC_ARMED` goes to `SYNC_ACTIVE` when VS is high; this transition is the commit point. `SYNC_ACTIVE` goes back to `SYNC_ARMED` when VS is low. VS filter states: `VSF_LOW` goes to `VSF_RISE` when VS is high. `VSF_RISE` goes to `VSF_HIGH` when VS is high, or back to `VSF_LOW` when VS is low. `VSF_HIGH` goes to `VSF_FALL` when VS is low. `VSF_FALL` goes to `VSF_LOW` when VS is low, or back to `VSF_HIGH` when VS is high. The filter output is high in `VSF_HIGH` and `VSF_FALL`.

Top module: `lvds_lane_packer`

## Requirements
- R1: While `rst_n` is low, on every clock edge `lane_data` becomes all zero and `vs_gpio` is 0. After reset the select shadow is the identity (physical lane i takes logical lane i) and the invert shadow is all zero.
- R2: With `cfg_wide`=1, the logical lanes of a port hold bits 5:0 of each color. Lane 0 is {G[0], R[5:0]}, with bit 6 at the left. Lane 1 is {B[1:0], G[5:1]}. Lane 2 is {DE, VS, HS, B[5:2]}. Lane 3 is {0, B[7:6], G[7:6], R[7:6]}.
- R3: With `cfg_wide`=0, lanes 0 to 2 use the same layout but take bits 7:2 of each color in place of bits 5:0, and logical lane 3 is all zero.
- R4: With `cfg_topo` equal to 0 (single 4-lane port) or 3 (reserved, which behaves as 0), physical lanes 4 to 7 (`lane_data[55:28]`) are zero.
- R5: With `cfg_topo`=1 (8-lane dual pixel), logical lanes 0 to 3 come from port A's pixel and logical lanes 4 to 7 from port B's colors. Both groups carry port A's DE, HS and VS.
- R6: With `cfg_topo`=2 (two separate ports), logical lanes 4 to 7 are packed from port B's colors and from port B's own DE, HS and VS.
- R7: Physical lane i (`lane_data[7i+6:7i]`) outputs the logical lane whose index is in `cfg_lane_sel[3i+2:3i]`. Two physical lanes that select the same logical lane output the same word.
- R8: When bit i of the effective invert setting is 1, all 7 bits of physical lane i are inverted. The unused lanes of R4 stay zero whatever their invert bit.
- R9: Select and invert writes take effect only from the pixel on which `a_vs` is 1 and the previous pixel had `a_vs`=0 (the `SYNC_ARMED` to `SYNC_ACTIVE` transition). No VS rise is recognised until VS has been seen low after reset. At every other pixel the shadowed values stay in use.
- R10: Inputs sampled on a clock edge appear on `lane_data` right after that same edge. The latency is exactly one cycle.
- R11: When `cfg_vs_gpio_en`=1, `vs_gpio` follows `a_vs` two edges late, and an `a_vs` pulse that lasts one cycle never reaches it. When `cfg_vs_gpio_en`=0, `vs_gpio` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_red | input | 8 | Port A red |
| a_grn | input | 8 | Port A green |
| a_blu | input | 8 | Port A blue |
| a_de | input | 1 | Port A data enable |
| a_hs | input | 1 | Port A horizontal sync |
| a_vs | input | 1 | Port A vertical sync; also the frame-sync reference |
| b_red | input | 8 | Port B red |
| b_grn | input | 8 | Port B green |
| b_blu | input | 8 | Port B blue |
| b_de | input | 1 | Port B data enable |
| b_hs | input | 1 | Port B horizontal sync |
| b_vs | input | 1 | Port B vertical sync |
| cfg_topo | input | 2 | 0 single 4-lane, 1 dual-pixel 8-lane, 2 two ports, 3 as 0 |
| cfg_wide | input | 1 | 1 = 24-bit four lanes, 0 = 18-bit three lanes |
| cfg_lane_sel | input | 24 | 3-bit logical lane select per physical lane |
| cfg_lane_inv | input | 8 | Invert bit per physical lane |
| cfg_vs_gpio_en | input | 1 | Enables the filtered VS output |
| lane_data | output | 56 | Seven-bit word per physical lane, lane i at bits 7i+6:7i |
| vs_gpio | output | 1 | Filtered VS output |

## Verification
The packing is driven with complementary bit patterns (A5/3C/F0 against 5A/C3/0F) and varied sync bits. These expose any bit that lands in the wrong lane position or comes from the wrong half of a color in either color width. Different port B colors and sync bits are then fed under each of the four topology codes. This separates port A's sync bits from port B's and shows that idle lanes are forced to zero. Lane select and invert settings, including a duplicated select, are written while VS is low and again across a VS rise; this shows whether the change is held back until the right pixel. A VS sequence with a single-cycle pulse and held levels, with the output both enabled and disabled, separates filtered from unfiltered behaviour.

// File: rtl/lvds_pkg.sv
package lvds_pkg;

    localparam int unsigned COLOR_W        = 8;
    localparam int unsigned WORD_W         = 7;
    localparam int unsigned LANES_PER_PORT = 4;
    localparam int unsigned NUM_PORTS      = 2;

    typedef enum logic [1:0] {
        TOPO_SINGLE4    = 2'd0,
        TOPO_DUAL_PIXEL = 2'd1,
        TOPO_TWO_PORT   = 2'd2,
        TOPO_RESERVED   = 2'd3
    } topo_e;

    typedef enum logic [1:0] {
        SYNC_HUNT   = 2'd0,
        SYNC_ARMED  = 2'd1,
        SYNC_ACTIVE = 2'd2
    } sync_state_e;

    typedef enum logic [1:0] {
        VSF_LOW  = 2'd0,
        VSF_RISE = 2'd1,
        VSF_HIGH = 2'd2,
        VSF_FALL = 2'd3
    } vsf_state_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               de;
        logic               hs;
        logic               vs;
    } pixel_t;

    // Six color bits carried on the three base lanes
    function automatic logic [5:0] base_bits(input logic [COLOR_W-1:0] c, input logic wide);
        return wide ? c[5:0] : c[7:2];
    endfunction

endpackage

// File: rtl/lane_pack.sv
module lane_pack
    import lvds_pkg::*;
#(
    parameter int unsigned LANES = LANES_PER_PORT,
    parameter int unsigned W     = WORD_W
) (
    input  pixel_t               pix,
    input  logic                 wide,
    output logic [LANES*W-1:0]   words
);

    logic [5:0] r6, g6, b6;
    logic [W-1:0] w0, w1, w2, w3;

    always_comb begin
        r6 = base_bits(pix.red, wide);
        g6 = base_bits(pix.grn, wide);
        b6 = base_bits(pix.blu, wide);
        w0 = {g6[0], r6[5:0]};
        w1 = {b6[1:0], g6[5:1]};
        w2 = {pix.de, pix.vs, pix.hs, b6[5:2]};
        if (wide) begin
            w3 = {1'b0, pix.blu[7:6], pix.grn[7:6], pix.red[7:6]};
        end else begin
            w3 = '0;
        end
        words = {w3, w2, w1, w0};
    end

endmodule

// File: rtl/frame_sync_fsm.sv
module frame_sync_fsm
    import lvds_pkg::*;
#(
    parameter int unsigned LANES = NUM_PORTS * LANES_PER_PORT,
    localparam int unsigned SEL_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vs,
    input  logic [LANES*SEL_W-1:0]  cfg_sel,
    input  logic [LANES-1:0]        cfg_inv,
    output logic [LANES*SEL_W-1:0]  eff_sel,
    output logic [LANES-1:0]        eff_inv
);

    sync_state_e state, state_nxt;
    logic                   commit;
    logic [LANES*SEL_W-1:0] shadow_sel;
    logic [LANES-1:0]       shadow_inv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SYNC_HUNT;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SYNC_HUNT:   if (!vs) state_nxt = SYNC_ARMED;
            SYNC_ARMED:  if (vs)  state_nxt = SYNC_ACTIVE;
            SYNC_ACTIVE: if (!vs) state_nxt = SYNC_ARMED;
            default:     state_nxt = SYNC_HUNT;
        endcase
    end

    always_comb begin
        commit  = (state == SYNC_ARMED) && vs;
        eff_sel = commit ? cfg_sel : shadow_sel;
        eff_inv = commit ? cfg_inv : shadow_inv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) begin
                shadow_sel[i*SEL_W +: SEL_W] <= SEL_W'(i);
            end
            shadow_inv <= '0;
        end else if (commit) begin
            shadow_sel <= cfg_sel;
            shadow_inv <= cfg_inv;
        end
    end

    // R9: settings move only on a recognised VS rise
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(shadow_sel) && $stable(shadow_inv)));

    assert_commit_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (vs && !$past(vs)));

endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
    import lvds_pkg::*;
#(
    parameter int unsigned LANES      = NUM_PORTS * LANES_PER_PORT,
    parameter int unsigned PORT_LANES = LANES_PER_PORT,
    parameter int unsigned W          = WORD_W,
    localparam int unsigned SEL_W     = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*W-1:0]      logical,
    input  logic [LANES*SEL_W-1:0]  eff_sel,
    input  logic [LANES-1:0]        eff_inv,
    input  logic                    single_port,
    output logic [LANES*W-1:0]      lane_data
);

    logic [W-1:0]       logical_arr [LANES];
    logic [LANES*W-1:0] lane_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_split
        assign logical_arr[l] = logical[l*W +: W];
    end

    for (genvar p = 0; p < LANES; p++) begin : g_phys
        logic [W-1:0] picked;
        always_comb begin
            picked = logical_arr[eff_sel[p*SEL_W +: SEL_W]] ^ {W{eff_inv[p]}};
        end
        if (p >= PORT_LANES) begin : g_second
            assign lane_nxt[p*W +: W] = single_port ? '0 : picked;
        end else begin : g_first
            assign lane_nxt[p*W +: W] = picked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_data <= '0;
        end else begin
            lane_data <= lane_nxt;
        end
    end

    // R4: second port is silent in single-port topologies
    assert_port_b_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        single_port |=> (lane_data[LANES*W-1:PORT_LANES*W] == '0));

    // R7: duplicated selection yields identical words
    assert_dup_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_sel[SEL_W-1:0] == eff_sel[2*SEL_W-1:SEL_W]) && (eff_inv[0] == eff_inv[1]))
        |=> (lane_data[W-1:0] == lane_data[2*W-1:W]));

endmodule

// File: rtl/vs_glitch_filter.sv
module vs_glitch_filter
    import lvds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vs_in,
    input  logic enable,
    output logic vs_out
);

    vsf_state_e state, state_nxt;
    logic level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= VSF_LOW;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            VSF_LOW:  if (vs_in)  state_nxt = VSF_RISE;
            VSF_RISE: state_nxt = vs_in ? VSF_HIGH : VSF_LOW;
            VSF_HIGH: if (!vs_in) state_nxt = VSF_FALL;
            VSF_FALL: state_nxt = vs_in ? VSF_HIGH : VSF_LOW;
            default:  state_nxt = VSF_LOW;
        endcase
    end

    always_comb begin
        level  = (state == VSF_HIGH) || (state == VSF_FALL);
        vs_out = enable && level;
    end

    // R11: output level only rises after two high samples
    assert_no_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> ($past(vs_in) && $past(vs_in, 2)));

endmodule

// File: rtl/lvds_lane_packer.sv
module lvds_lane_packer
    import lvds_pkg::*;
#(
    parameter int unsigned PORT_LANES = LANES_PER_PORT,
    parameter int unsigned PORTS      = NUM_PORTS,
    localparam int unsigned LANES     = PORTS * PORT_LANES,
    localparam int unsigned SEL_W     = $clog2(LANES),
    localparam int unsigned W         = WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [COLOR_W-1:0]     a_red,
    input  logic [COLOR_W-1:0]     a_grn,
    input  logic [COLOR_W-1:0]     a_blu,
    input  logic                   a_de,
    input  logic                   a_hs,
    input  logic                   a_vs,
    input  logic [COLOR_W-1:0]     b_red,
    input  logic [COLOR_W-1:0]     b_grn,
    input  logic [COLOR_W-1:0]     b_blu,
    input  logic                   b_de,
    input  logic                   b_hs,
    input  logic                   b_vs,
    input  logic [1:0]             cfg_topo,
    input  logic                   cfg_wide,
    input  logic [LANES*SEL_W-1:0] cfg_lane_sel,
    input  logic [LANES-1:0]       cfg_lane_inv,
    input  logic                   cfg_vs_gpio_en,
    output logic [LANES*W-1:0]     lane_data,
    output logic                   vs_gpio
);

    topo_e                  topo;
    logic                   single_port;
    pixel_t                 pix [PORTS];
    logic [LANES*W-1:0]     logical;
    logic [LANES*SEL_W-1:0] eff_sel;
    logic [LANES-1:0]       eff_inv;

    always_comb begin
        topo        = topo_e'(cfg_topo);
        single_port = 1'b0;
        pix[0]      = '{red: a_red, grn: a_grn, blu: a_blu, de: a_de, hs: a_hs, vs: a_vs};
        pix[1]      = '{red: b_red, grn: b_grn, blu: b_blu, de: b_de, hs: b_hs, vs: b_vs};
        unique case (topo)
            TOPO_SINGLE4, TOPO_RESERVED: single_port = 1'b1;
            TOPO_DUAL_PIXEL: begin
                pix[1].de = a_de;
                pix[1].hs = a_hs;
                pix[1].vs = a_vs;
            end
            TOPO_TWO_PORT: single_port = 1'b0;
            default: single_port = 1'b1;
        endcase
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        lane_pack #(.LANES(PORT_LANES), .W(W)) u_pack (
            .pix   (pix[g]),
            .wide  (cfg_wide),
            .words (logical[g*PORT_LANES*W +: PORT_LANES*W])
        );
    end

    frame_sync_fsm #(.LANES(LANES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs      (a_vs),
        .cfg_sel (cfg_lane_sel),
        .cfg_inv (cfg_lane_inv),
        .eff_sel (eff_sel),
        .eff_inv (eff_inv)
    );

    lane_xbar #(.LANES(LANES), .PORT_LANES(PORT_LANES), .W(W)) u_xbar (
        .clk         (clk),
        .rst_n       (rst_n),
        .logical     (logical),
        .eff_sel     (eff_sel),
        .eff_inv     (eff_inv),
        .single_port (single_port),
        .lane_data   (lane_data)
    );

    vs_glitch_filter u_vsf (
        .clk    (clk),
        .rst_n  (rst_n),
        .vs_in  (a_vs),
        .enable (cfg_vs_gpio_en),
        .vs_out (vs_gpio)
    );

endmodule

// File: tb/lvds_lane_packer_test.sv
module lvds_lane_packer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] a_red = '0, a_grn = '0, a_blu = '0;
    logic [7:0] b_red = '0, b_grn = '0, b_blu = '0;
    logic a_de = 0, a_hs = 0, a_vs = 0, b_de = 0, b_hs = 0, b_vs = 0;
    logic [1:0]  cfg_topo = 2'd0;
    logic        cfg_wide = 1'b1;
    logic [23:0] cfg_lane_sel;
    logic [7:0]  cfg_lane_inv = '0;
    logic        cfg_vs_gpio_en = 1'b0;
    logic [55:0] lane_data;
    logic        vs_gpio;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [55:0] lanes;
        logic        vs;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Bench-side reference state
    logic [23:0] m_sel;
    logic [7:0]  m_inv = '0;
    bit          m_armed = 0;
    logic        m_vsd = 0, m_filt = 0;

    always #4 clk = ~clk;

    lvds_lane_packer uut (
        .clk(clk), .rst_n(rst_n),
        .a_red(a_red), .a_grn(a_grn), .a_blu(a_blu), .a_de(a_de), .a_hs(a_hs), .a_vs(a_vs),
        .b_red(b_red), .b_grn(b_grn), .b_blu(b_blu), .b_de(b_de), .b_hs(b_hs), .b_vs(b_vs),
        .cfg_topo(cfg_topo), .cfg_wide(cfg_wide), .cfg_lane_sel(cfg_lane_sel),
        .cfg_lane_inv(cfg_lane_inv), .cfg_vs_gpio_en(cfg_vs_gpio_en),
        .lane_data(lane_data), .vs_gpio(vs_gpio)
    );

    function automatic logic [23:0] ident_sel();
        logic [23:0] s;
        for (int i = 0; i < 8; i++) s[i*3 +: 3] = 3'(i);
        return s;
    endfunction

    // Four logical lanes of one port per R2/R3
    function automatic logic [27:0] ref_port(input logic [7:0] r, input logic [7:0] g,
                                             input logic [7:0] b, input logic de,
                                             input logic hs, input logic vs, input logic wide);
        logic [5:0] r6, g6, b6;
        logic [6:0] l0, l1, l2, l3;
        r6 = wide ? r[5:0] : r[7:2];
        g6 = wide ? g[5:0] : g[7:2];
        b6 = wide ? b[5:0] : b[7:2];
        for (int k = 0; k < 6; k++) l0[k] = r6[k];
        l0[6] = g6[0];
        for (int k = 0; k < 5; k++) l1[k] = g6[k+1];
        l1[5] = b6[0]; l1[6] = b6[1];
        for (int k = 0; k < 4; k++) l2[k] = b6[k+2];
        l2[4] = hs; l2[5] = vs; l2[6] = de;
        l3 = wide ? {1'b0, b[7:6], g[7:6], r[7:6]} : 7'd0;
        return {l3, l2, l1, l0};
    endfunction

    // One pixel per cycle: reference model push, then advance one clock
    task automatic step(input string tag);
        exp_t e;
        logic [55:0] logical;
        logic [27:0] pa, pb;
        logic [23:0] s;
        logic [7:0]  v;
        bit single;
        bit commit;
        commit = m_armed && a_vs;
        s = commit ? cfg_lane_sel : m_sel;
        v = commit ? cfg_lane_inv : m_inv;
        if (commit) begin m_sel = cfg_lane_sel; m_inv = cfg_lane_inv; end
        m_armed = !a_vs;
        single = (cfg_topo == 2'd0) || (cfg_topo == 2'd3);
        pa = ref_port(a_red, a_grn, a_blu, a_de, a_hs, a_vs, cfg_wide);
        if (cfg_topo == 2'd1) pb = ref_port(b_red, b_grn, b_blu, a_de, a_hs, a_vs, cfg_wide);
        else                  pb = ref_port(b_red, b_grn, b_blu, b_de, b_hs, b_vs, cfg_wide);
        logical = {pb, pa};
        for (int p = 0; p < 8; p++) begin
            logic [6:0] w;
            w = logical[s[p*3 +: 3]*7 +: 7] ^ {7{v[p]}};
            if (single && p >= 4) w = '0;
            e.lanes[p*7 +: 7] = w;
        end
        if (a_vs == m_vsd) m_filt = a_vs;
        m_vsd = a_vs;
        e.vs  = cfg_vs_gpio_en && m_filt;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare between edges
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (lane_data !== e.lanes) begin
                errors++;
                $display("FAIL %s lane_data got %h expected %h", e.tag, lane_data, e.lanes);
            end
            checks++;
            if (vs_gpio !== e.vs) begin
                errors++;
                $display("FAIL %s vs_gpio got %b expected %b", e.tag, vs_gpio, e.vs);
            end
        end
    end

    task automatic set_a(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input logic de, input logic hs, input logic vs);
        a_red = r; a_grn = g; a_blu = b; a_de = de; a_hs = hs; a_vs = vs;
    endtask

    task automatic set_b(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input logic de, input logic hs, input logic vs);
        b_red = r; b_grn = g; b_blu = b; b_de = de; b_hs = hs; b_vs = vs;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R10 watchdog got no completion expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] rev;
        cfg_lane_sel = ident_sel();
        m_sel = ident_sel();
        cfg_vs_gpio_en = 1'b1;
        a_vs = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset clears outputs
        checks++;
        if (lane_data !== '0 || vs_gpio !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset got %h/%b expected 0/0", lane_data, vs_gpio);
        end
        @(negedge clk);
        cfg_vs_gpio_en = 1'b0;
        set_a(8'hA5, 8'h3C, 8'hF0, 1, 0, 0);
        set_b(8'h11, 8'h22, 8'h33, 1, 1, 1);
        rst_n = 1'b1;

        // R2 R10 R4: wide packing, single port
        step("R2 R10 R4 wide pattern 1");
        set_a(8'h5A, 8'hC3, 8'h0F, 0, 1, 0);
        step("R2 R4 wide pattern 2");
        cfg_topo = 2'd3;
        step("R4 reserved topology");
        // R3: narrow packing
        cfg_topo = 2'd0; cfg_wide = 1'b0;
        step("R3 narrow pattern 2");
        set_a(8'hA5, 8'h3C, 8'hF0, 1, 0, 0);
        step("R3 narrow pattern 1");
        // R5 dual pixel
        cfg_wide = 1'b1; cfg_topo = 2'd1;
        set_b(8'hC6, 8'h9D, 8'h72, 0, 1, 1);
        step("R5 dual pixel");
        cfg_wide = 1'b0;
        step("R5 dual pixel narrow");
        // R6 two ports
        cfg_wide = 1'b1; cfg_topo = 2'd2;
        step("R6 two ports");
        set_b(8'h39, 8'h62, 8'h8D, 1, 0, 0);
        step("R6 two ports b sync");

        // R9: new select held back while VS low
        for (int i = 0; i < 8; i++) rev[i*3 +: 3] = 3'(7 - i);
        rev[5:3] = rev[2:0];
        cfg_lane_sel = rev;
        step("R9 select held");
        step("R9 select held 2");
        a_vs = 1'b1;
        step("R7 R9 select at VS rise");
        set_a(8'h12, 8'h34, 8'h56, 1, 1, 1);
        step("R7 remapped with duplicate");
        a_vs = 1'b0;
        cfg_lane_inv = 8'h5A;
        step("R9 invert held");
        a_vs = 1'b1;
        step("R8 invert at VS rise");
        cfg_topo = 2'd0;
        step("R8 invert with idle lanes R4");
        cfg_topo = 2'd2;
        cfg_lane_inv = 8'hFF;
        cfg_lane_sel = ident_sel();
        step("R9 no commit while VS high");

        // R11: VS filter
        cfg_vs_gpio_en = 1'b1;
        a_vs = 0; step("R11 low");
        a_vs = 0; step("R11 low");
        a_vs = 1; step("R11 single pulse");
        a_vs = 0; step("R11 after pulse");
        a_vs = 0; step("R11 low again");
        a_vs = 1; step("R11 rise 1");
        a_vs = 1; step("R11 rise 2");
        a_vs = 1; step("R11 held high");
        a_vs = 0; step("R11 single low dip");
        a_vs = 1; step("R11 back high");
        a_vs = 0; step("R11 fall 1");
        a_vs = 0; step("R11 fall 2");
        a_vs = 1; step("R11 rise disabled prep");
        cfg_vs_gpio_en = 1'b0;
        a_vs = 1; step("R11 disabled high");
        a_vs = 1; step("R11 disabled held");

        @(posedge clk);
        #3;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule